// File: doc/BRIEF.md
# Vector Lane Shifter with Per-Lane Signed Counts

This block shifts every lane of a vector operand by its own amount. The amount for each lane comes from the matching lane of a second vector operand, read as a signed byte. A positive or zero amount shifts the lane left. A negative amount shifts it right by the magnitude, either arithmetically or logically as a mode input selects. Any amount whose magnitude reaches the lane width clears that lane.

A two-bit size input sets the lane width to 8, 16, 32 or 64 bits. A register-form input selects a 64-bit or a 128-bit vector. In the 64-bit form only the low half carries lanes, and the high half of the result reads as zero. All inputs are sampled on a start pulse. The result is registered and appears with a one-cycle valid strobe on the following cycle. It then stays unchanged until the next start.

Top module: `lane_shift_unit`

## Requirements
- R1: Each lane's shift amount is bits [7:0] of the matching lane of `opB`, read as a two's-complement byte. All higher bits of that `opB` lane are ignored.
- R2: An amount n in 0..W-1, where W = 8 << `laneSize`, shifts the lane of `opA` left by n. Zeros fill from the bottom and bits beyond W are dropped.
- R3: With `signedMode`=0, an amount -n with n in 1..W-1 shifts the lane right by n and fills with zeros.
- R4: With `signedMode`=1, an amount -n with n in 1..W-1 shifts the lane right by n and fills with copies of the lane's top bit.
- R5: Any amount whose magnitude is W or more gives a zero lane, in either direction and in either mode. This includes -128.
- R6: `laneSize` values 0, 1, 2 and 3 select lanes of 8, 16, 32 and 64 bits. Lane k occupies bits [k*W +: W]. No bit moves from one lane into another.
- R7: With `wideReg`=0 (64-bit form), `result[127:64]` is zero and only the lanes in the low 64 bits are shifted. With `wideReg`=1, all 128/W lanes are shifted.
- R8: After reset, `result` is zero and `resultValid` is low. `resultValid` is high exactly in the cycle after a cycle with `start` high. Otherwise it is low.
- R9: `result` changes only on a start. Changes to the other inputs without a start have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample operands and launch one operation |
| opA | input | 128 | Vector whose lanes are shifted |
| opB | input | 128 | Vector whose lanes supply the signed shift amounts |
| laneSize | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| wideReg | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| signedMode | input | 1 | 1 = arithmetic right shift, 0 = logical right shift |
| result | output | 128 | Registered shifted vector |
| resultValid | output | 1 | One-cycle strobe after each start |

## Verification
Within one operation, different lanes can need different treatments at the same time. One lane may shift left, its neighbour may shift right, and a third may be cleared for exceeding the lane width. The 64-bit form also clears the high half in the same cycle. The sweep provokes this by giving neighbouring lanes amounts one apart around a common base value, so the lanes around zero and around ±W mix directions and clearing. The same operations run in both register forms and both right-shift modes. Each whole vector is judged against a bench model that shifts one bit at a time, with random noise placed above each lane's count byte.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadRes;   // capture the next result this edge
  } shiftStrobe_t;

  localparam int SIZE_CODES = 4;
  localparam int CNT_BITS   = 8;
endpackage

// File: rtl/lane_shift_lane.sv
module lane_shift_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0]  laneA,
  input  logic [7:0]     laneCnt,
  input  logic           signedMode,
  output logic [LW-1:0]  laneY
);
  logic       isNeg;
  logic [8:0] mag;
  logic       tooFar;

  always_comb begin
    isNeg  = laneCnt[7];
    // magnitude in 9 bits so that -128 becomes 128
    mag    = isNeg ? (9'd0 - {1'b1, laneCnt}) : {1'b0, laneCnt};
    tooFar = (mag >= 9'(LW));
    if (tooFar)
      laneY = '0;
    else if (!isNeg)
      laneY = laneA << mag;
    else if (signedMode)
      laneY = LW'($signed(laneA) >>> mag);
    else
      laneY = laneA >> mag;
  end
endmodule

// File: rtl/lane_shift_ctrl.sv
module lane_shift_ctrl
  import lane_shift_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output shiftStrobe_t strb,
  output logic         resultValid
);
  always_comb strb.loadRes = start;

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= start;
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resultValid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resultValid); // R8
endmodule

// File: rtl/lane_shift_datapath.sv
module lane_shift_datapath
  import lane_shift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobe_t     strb,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [1:0]       laneSize,
  input  logic             wideReg,
  input  logic             signedMode,
  output logic [VEC_W-1:0] result
);
  localparam int HALF = VEC_W / 2;

  logic [VEC_W-1:0] sizeSel;
  logic [VEC_W-1:0] nextRes;

  for (genvar s = 0; s < SIZE_CODES; s++) begin : gSize
    localparam int LW = 8 << s;
    localparam int NL = VEC_W / LW;
    logic [VEC_W-1:0] part;
    for (genvar l = 0; l < NL; l++) begin : gLane
      lane_shift_lane #(.LW(LW)) uLane (
        .laneA      (opA[l*LW +: LW]),
        .laneCnt    (opB[l*LW +: CNT_BITS]),
        .signedMode (signedMode),
        .laneY      (part[l*LW +: LW])
      );
    end
  end

  always_comb begin
    case (laneSize)
      2'd0:    sizeSel = gSize[0].part;
      2'd1:    sizeSel = gSize[1].part;
      2'd2:    sizeSel = gSize[2].part;
      default: sizeSel = gSize[3].part;
    endcase
    nextRes = wideReg ? sizeSel : {{HALF{1'b0}}, sizeSel[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             result <= '0;
    else if (strb.loadRes) result <= nextRes;
  end

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRes && !wideReg) |=> (result[VEC_W-1:HALF] == '0)); // R7
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRes && wideReg && opB == '0) |=> (result == $past(opA))); // R2
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRes |=> $stable(result)); // R9
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lane_shift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [1:0]       laneSize,
  input  logic             wideReg,
  input  logic             signedMode,
  output logic [VEC_W-1:0] result,
  output logic             resultValid
);
  shiftStrobe_t strb;

  lane_shift_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .strb        (strb),
    .resultValid (resultValid)
  );

  lane_shift_datapath #(.VEC_W(VEC_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .opA        (opA),
    .opB        (opB),
    .laneSize   (laneSize),
    .wideReg    (wideReg),
    .signedMode (signedMode),
    .result     (result)
  );
endmodule

// File: tb/lane_shift_unit_test.sv
module lane_shift_unit_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [1:0]   laneSize = '0;
  logic         wideReg = 1'b0;
  logic         signedMode = 1'b0;
  logic [127:0] result;
  logic         resultValid;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_shift_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .laneSize(laneSize), .wideReg(wideReg), .signedMode(signedMode),
    .result(result), .resultValid(resultValid)
  );

  // Bit-serial reference: one single-bit step per unit of shift amount
  function automatic logic [127:0] refVec(logic [127:0] a, logic [127:0] b,
                                          int sz, bit wd, bit sg);
    logic [127:0] r = '0;
    int w = 8 << sz;
    int lanes = (wd ? 16 : 8) >> sz;
    for (int l = 0; l < lanes; l++) begin
      logic [63:0] v = '0;
      logic [7:0]  cb = '0;
      int c;
      for (int i = 0; i < w; i++) v[i] = a[l*w + i];
      for (int i = 0; i < 8; i++) cb[i] = b[l*w + i];
      c = int'($signed(cb));
      if (c >= w || -c >= w) v = '0;
      else if (c >= 0) begin
        for (int k = 0; k < c; k++) begin
          for (int i = 63; i > 0; i--) v[i] = v[i-1];
          v[0] = 1'b0;
        end
      end else begin
        for (int k = 0; k < -c; k++) begin
          logic top = v[w-1];
          for (int i = 0; i < 63; i++) v[i] = v[i+1];
          v[63] = 1'b0;
          v[w-1] = sg ? top : 1'b0;
        end
      end
      for (int i = 0; i < w; i++) r[l*w + i] = v[i];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [127:0] a, logic [127:0] b, int sz, bit wd, bit sg);
    @(negedge clk);
    opA = a; opB = b; laneSize = 2'(sz); wideReg = wd; signedMode = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] a, b, e, held;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset result", result, '0);
    check("R8 reset valid", {127'd0, resultValid}, 128'd0);
    rstN = 1'b1;

    // R8 valid strobe timing
    runOp(128'h1, 128'h1, 0, 1'b1, 1'b0);
    check("R8 valid after start", {127'd0, resultValid}, 128'd1);
    check("R2 single bit left", result, 128'h2);
    @(negedge clk);
    check("R8 valid drops", {127'd0, resultValid}, 128'd0);

    // R1 upper bits of count lane ignored
    a = 128'h0123_4567_89ab_cdef_0f1e_2d3c_4b5a_6978;
    runOp(a, {8{16'h0003}}, 1, 1'b1, 1'b0);
    e = result;
    runOp(a, {8{16'hA503}}, 1, 1'b1, 1'b0);
    check("R1 upper count bits ignored", result, e);
    check("R1 count value", e, refVec(a, {8{16'h0003}}, 1, 1'b1, 1'b0));

    // R5 -128 clears, +127 clears
    runOp(rnd128(), {16{8'h80}}, 0, 1'b1, 1'b1);
    check("R5 minus 128 zero", result, '0);
    runOp(rnd128(), {2{64'h7f}}, 3, 1'b1, 1'b0);
    check("R5 plus 127 zero", result, '0);

    // R4 vs R3 on negative top bit, 64-bit lanes
    a = {2{64'h8000_0000_0000_0000}};
    runOp(a, {2{64'hff}}, 3, 1'b1, 1'b1);
    check("R4 arithmetic fill", result, {2{64'hC000_0000_0000_0000}});
    runOp(a, {2{64'hff}}, 3, 1'b1, 1'b0);
    check("R3 logical fill", result, {2{64'h4000_0000_0000_0000}});

    // R9 inputs change without start
    held = result;
    @(negedge clk);
    opA = rnd128(); opB = rnd128(); laneSize = 2'd0; signedMode = 1'b1; wideReg = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 result held", result, held);
    check("R9 no valid", {127'd0, resultValid}, 128'd0);

    // Sweep all configurations and a window of counts
    for (int sz = 0; sz < 4; sz++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int ci = -72; ci <= 73; ci++) begin
            int w = 8 << sz;
            int c = (ci == 73) ? -128 : ci;
            string tag;
            a = rnd128();
            b = rnd128();
            for (int l = 0; l < 128 / w; l++)
              b[l*w +: 8] = 8'(c + (l % 3) - 1);
            e = refVec(a, b, sz, wd[0], sg[0]);
            runOp(a, b, sz, wd[0], sg[0]);
            if (wd == 0) tag = "R7 narrow form";
            else if (c - 1 >= w || -(c + 1) >= w) tag = "R5 beyond width";
            else if (c > 1) tag = "R2 left sweep";
            else if (c < -1) tag = sg ? "R4 arithmetic sweep" : "R3 logical sweep";
            else tag = "R6 mixed lanes";
            check(tag, result, e);
          end
        end
      end
    end

    // R6 lane isolation: all-ones lanes shifted, per size
    for (int sz = 0; sz < 4; sz++) begin
      runOp({128{1'b1}}, {16{8'h01}}, sz, 1'b1, 1'b0);
      check("R6 lane isolation", result, refVec({128{1'b1}}, {16{8'h01}}, sz, 1'b1, 1'b0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule